// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock for an I2C master. A prescaler divides the input clock down to a module-clock tick. Two programmable phase lengths, one for the low phase and one for the high phase, set how many module-clock periods SCL stays at each level. Each phase is also lengthened by a fixed offset of 5, 6 or 7 module periods, and the prescaler setting picks which offset applies.

A bus controller sets the three values through a small register port, then raises `enable`. SCL goes low on the next clock edge and then alternates between its two phases. A one-cycle strobe marks every rising and falling edge the generator makes, so the controller can align data changes and sampling to it. When `enable` drops, SCL is released high at once and all counting state is cleared.

Top module: `scl_timegen`

## Requirements
- R1: Register map on `reg_addr`: 0 = prescaler value P (the low PSC_W bits of `reg_wdata` are kept, 8 by default), 1 = low-phase value L (16 bits), 2 = high-phase value H (16 bits). A write happens on a clock edge with `reg_wr` high. `reg_rdata` shows the zero-extended register selected by `reg_addr` one clock after the address is applied. Address 3 reads 0, and writes to it change nothing.
- R2: After synchronous reset all three registers read 0, `scl_o` is 1 and both strobes are 0.
- R3: The module-clock tick comes once every P+1 input clocks.
- R4: The phase offset d is 7 when P = 0, 6 when P = 1 and 5 when P is 2 or more.
- R5: On the clock edge that first samples `enable` high, SCL goes low. The low phase lasts (L + d) × (P + 1) input clocks.
- R6: The high phase lasts (H + d) × (P + 1) input clocks, and the two phases then alternate.
- R7: A phase value of zero gives a phase of d module periods. SCL never stops toggling, and no low phase is shorter than 5 clocks.
- R8: `scl_fall` is high for exactly the first cycle in which SCL is low after a generator edge. `scl_rise` is high for exactly the first cycle in which SCL is high after a generator edge. The two strobes are never high together.
- R9: A register write made during a phase does not change that phase. The new values take effect from the next phase boundary on.
- R10: While `enable` is low, SCL is high from the next edge, no strobe fires, and the prescaler and phase counters are cleared. A later enable therefore starts a complete low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | DIV_W | Write data |
| reg_rdata | output | DIV_W | Registered read data |
| scl_o | output | 1 | SCL level (1 = released) |
| scl_rise | output | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe on an SCL falling edge |

## Verification
The bench measures phase lengths at the three prescaler values that select different offsets. A wrong offset table shifts every phase by a multiple of P+1 clocks, so each of those measurements would fail. It also sets zero phase values: an off-by-one terminal count would give d-1 periods or stall SCL. A register write in the middle of a long low phase has to leave that phase unchanged and then show up in the following phases. A design that reloads mid-phase gives a shortened or stretched low time. Dropping `enable` partway through a phase, while the prescaler is mid-count, must release SCL with no strobe. The next enable must then give a full low phase, which a design that keeps stale counts would cut short.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Fixed extension of each phase, in module-clock periods
  function automatic logic [2:0] phase_offset(input logic [31:0] psc);
    if (psc == 32'd0)      return 3'd7;
    else if (psc == 32'd1) return 3'd6;
    else                   return 3'd5;
  endfunction

endpackage

// File: rtl/scl_regs.sv
module scl_regs #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DIV_W-1:0] wdata,
  output logic [PSC_W-1:0] psc_o,
  output logic [DIV_W-1:0] low_o,
  output logic [DIV_W-1:0] high_o,
  output logic [DIV_W-1:0] rdata_o
);
  import scl_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_o  <= '0;
      low_o  <= '0;
      high_o <= '0;
    end else if (wr) begin
      case (sel)
        SEL_PSC:  psc_o  <= wdata[PSC_W-1:0];
        SEL_LOW:  low_o  <= wdata;
        SEL_HIGH: high_o <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (sel)
        SEL_PSC:  rdata_o <= DIV_W'(psc_o);
        SEL_LOW:  rdata_o <= low_o;
        SEL_HIGH: rdata_o <= high_o;
        default:  rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);

  logic [PSC_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/scl_phase.sv
module scl_phase #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc_reg,
  input  logic [DIV_W-1:0] low_reg,
  input  logic [DIV_W-1:0] high_reg,
  output logic             run_o,
  output logic [PSC_W-1:0] psc_act_o,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o
);
  import scl_pkg::*;

  localparam int LEN_W = DIV_W + 1;

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic             last_tick;

  assign low_len   = {1'b0, low_reg}  + LEN_W'(phase_offset(32'(psc_reg)));
  assign high_len  = {1'b0, high_reg} + LEN_W'(phase_offset(32'(psc_reg)));
  assign last_tick = tick && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      run_o     <= 1'b0;
      scl_o     <= 1'b1;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      psc_act_o <= '0;
    end else if (!run_o) begin
      run_o     <= 1'b1;
      scl_o     <= 1'b0;
      fall_o    <= 1'b1;
      rise_o    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= low_len;
      psc_act_o <= psc_reg;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (last_tick) begin
        cnt_q     <= '0;
        scl_o     <= !scl_o;
        rise_o    <= !scl_o;
        fall_o    <= scl_o;
        len_q     <= scl_o ? low_len : high_len;
        psc_act_o <= psc_reg;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_timegen.sv
module scl_timegen #(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DIV_W-1:0] reg_wdata,
  output logic [DIV_W-1:0] reg_rdata,
  output logic             scl_o,
  output logic             scl_rise,
  output logic             scl_fall
);

  logic [PSC_W-1:0] psc_reg;
  logic [DIV_W-1:0] low_reg;
  logic [DIV_W-1:0] high_reg;
  logic [PSC_W-1:0] psc_act;
  logic             run;
  logic             tick;

  scl_regs #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .psc_o   (psc_reg),
    .low_o   (low_reg),
    .high_o  (high_reg),
    .rdata_o (reg_rdata)
  );

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .limit (psc_act),
    .tick  (tick)
  );

  scl_phase #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .tick      (tick),
    .psc_reg   (psc_reg),
    .low_reg   (low_reg),
    .high_reg  (high_reg),
    .run_o     (run),
    .psc_act_o (psc_act),
    .scl_o     (scl_o),
    .rise_o    (scl_rise),
    .fall_o    (scl_fall)
  );

endmodule

// File: rtl/scl_timegen_chk.sv
module scl_timegen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_o,
  input logic scl_rise,
  input logic scl_fall
);

  logic       prev_scl;
  logic [3:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_scl <= 1'b1;
      run_len  <= '0;
    end else begin
      prev_scl <= scl_o;
      if (scl_o != prev_scl) run_len <= 4'd1;
      else if (run_len != 4'hF) run_len <= run_len + 1'b1;
    end
  end

  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_o && !scl_rise && !scl_fall));

  assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> (!scl_o && scl_fall));

  assert_rise_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_o) && $past(enable)) |-> scl_rise);

  assert_fall_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_o) |-> scl_fall);

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall}));

  assert_strobe_level_R8: assert property (@(posedge clk) disable iff (rst)
    (scl_rise |-> scl_o) and (scl_fall |-> !scl_o));

  assert_min_low_R7: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> (run_len >= 4'd5));

endmodule

bind scl_timegen scl_timegen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .scl_o    (scl_o),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall)
);

// File: tb/scl_timegen_bench.sv
module scl_timegen_bench;

  localparam int DIV_W = 16;
  localparam int NV = 6;
  localparam int unsigned V_PSC  [NV] = '{0, 1, 2, 5, 0, 3};
  localparam int unsigned V_LOW  [NV] = '{1, 3, 0, 10, 0, 2};
  localparam int unsigned V_HIGH [NV] = '{1, 2, 4, 0, 0, 7};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [DIV_W-1:0] reg_wdata = '0;
  logic [DIV_W-1:0] reg_rdata;
  logic             scl_o, scl_rise, scl_fall;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  scl_timegen #(.PSC_W(8), .DIV_W(DIV_W)) u_scl_timegen (
    .clk(clk), .rst(rst), .enable(enable), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  function automatic int d_of(input int unsigned p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int unsigned v);
    reg_addr  = a;
    reg_wdata = v[DIV_W-1:0];
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic measure(output int lo, output int hi, output int lo2,
                         output int fs, output int rs, output int fs2);
    @(negedge clk);
    fs = int'(scl_fall);
    lo = 0;
    while (!scl_o) begin lo++; @(negedge clk); end
    rs = int'(scl_rise);
    hi = 0;
    while (scl_o) begin hi++; @(negedge clk); end
    fs2 = int'(scl_fall);
    lo2 = 0;
    while (!scl_o) begin lo2++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v, lo, hi, lo2, fs, rs, fs2, p, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: reset state
    chk("R2 scl after reset", int'(scl_o), 1);
    chk("R2 strobes after reset", int'(scl_rise) + int'(scl_fall), 0);
    rd(2'd0, v); chk("R2 psc reset", v, 0);
    rd(2'd1, v); chk("R2 low reset", v, 0);
    rd(2'd2, v); chk("R2 high reset", v, 0);

    // R1: readback, truncation, unused address
    wr(2'd0, 32'h1AB);
    wr(2'd1, 32'h1234);
    wr(2'd2, 32'hBEEF);
    wr(2'd3, 32'hFFFF);
    rd(2'd0, v); chk("R1 psc readback truncated", v, 32'hAB);
    rd(2'd1, v); chk("R1 low readback", v, 32'h1234);
    rd(2'd2, v); chk("R1 high readback", v, 32'hBEEF);
    rd(2'd3, v); chk("R1 unused address reads zero", v, 0);

    // R3 R4 R5 R6 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_PSC[i]);
      wr(2'd1, V_LOW[i]);
      wr(2'd2, V_HIGH[i]);
      enable = 1'b1;
      measure(lo, hi, lo2, fs, rs, fs2);
      p = int'(V_PSC[i]);
      d = d_of(V_PSC[i]);
      chk((V_LOW[i] == 0) ? "R7 R5 R4 R3 low phase" : "R5 R4 R3 low phase",
          lo, (int'(V_LOW[i]) + d) * (p + 1));
      chk((V_HIGH[i] == 0) ? "R7 R6 R4 R3 high phase" : "R6 R4 R3 high phase",
          hi, (int'(V_HIGH[i]) + d) * (p + 1));
      chk("R6 repeated low phase", lo2, (int'(V_LOW[i]) + d) * (p + 1));
      chk("R8 strobes at edges", fs + rs + fs2, 3);
      enable = 1'b0;
      @(negedge clk);
    end

    // R9: mid-phase write
    wr(2'd0, 0);
    wr(2'd1, 20);
    wr(2'd2, 3);
    enable = 1'b1;
    fork
      begin
        repeat (5) @(negedge clk);
        wr(2'd1, 1);
        wr(2'd2, 2);
      end
      measure(lo, hi, lo2, fs, rs, fs2);
    join
    chk("R9 current low phase unchanged", lo, 27);
    chk("R9 next high phase uses new value", hi, 9);
    chk("R9 next low phase uses new value", lo2, 8);
    enable = 1'b0;
    @(negedge clk);

    // R10: disable mid-phase, then restart
    wr(2'd0, 1);
    wr(2'd1, 4);
    wr(2'd2, 4);
    enable = 1'b1;
    repeat (7) @(negedge clk);
    chk("R10 low before disable", int'(scl_o), 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 scl released", int'(scl_o), 1);
    chk("R10 no strobe on release", int'(scl_rise) + int'(scl_fall), 0);
    repeat (3) @(negedge clk);
    chk("R10 scl stays released", int'(scl_o), 1);
    enable = 1'b1;
    measure(lo, hi, lo2, fs, rs, fs2);
    chk("R10 full low phase after restart", lo, 20);
    chk("R10 high phase after restart", hi, 20);
    enable = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule